// File: doc/BRIEF.md
# Multi-Format Integer Adder/Subtractor

This block is a purely combinational arithmetic unit of parameterised width N. It adds two operands, subtracts the second from the first, or negates the first. The caller picks one of four number encodings: plain unsigned binary, sign-magnitude, one's complement or two's complement. Every operation is resolved within the same cycle. The block returns an N-bit result together with two flags: a signed overflow flag and an unsigned out-of-range flag.

All four encodings share a single ripple-carry building block. The one's and two's complement encodings share one path, and the one's complement result gets a second carry pass that folds the carry out of the top bit back into bit 0. Sign-magnitude has its own path. That path compares the two magnitudes, subtracts the smaller magnitude from the larger one when the effective signs differ, and always reports zero as positive zero.

Top module: `mfa_addsub`

## Requirements
- R1: `fmt` selects the encoding: 0 = unsigned, 1 = sign-magnitude (bit N-1 is the sign, bits N-2..0 are the magnitude), 2 = one's complement, 3 = two's complement. `op` selects the operation: 0 = add, 1 = subtract (A minus B), 2 = negate A (B is ignored), 3 = reserved.
- R2: Unsigned add gives (A+B) mod 2^N, and `oor` equals the carry out of bit N-1.
- R3: Unsigned subtract gives (A-B) mod 2^N with `oor` set exactly when A < B (a borrow out). Unsigned negate gives (0-A) mod 2^N with `oor` set exactly when A is nonzero.
- R4: Sign-magnitude with equal effective signs adds the magnitudes. The result keeps the common sign, and its magnitude is the low N-1 bits of the sum. `ovf` equals the carry out of the magnitude's top bit.
- R5: Sign-magnitude with different effective signs subtracts the smaller magnitude from the larger one. The result takes the sign of the operand with the larger magnitude, and `ovf` is 0.
- R6: Sign-magnitude subtract inverts the sign of B and then follows R4 or R5. Negate inverts only the sign of A. Any result with a zero magnitude has a sign bit of 0.
- R7: One's complement add computes A+B and then adds the carry out of bit N-1 back in at bit 0. Subtract does the same with the bitwise inverse of B. When `ovf` is 0, the result has the arithmetic value of the true sum or difference.
- R8: One's complement `ovf` is the XOR of the carry out of bit N-1 and the carry into bit N-1, both taken from the first addition. Negate returns ~A with `ovf` 0.
- R9: Two's complement add and subtract give (A±B) mod 2^N, and `ovf` is set exactly when the true value falls outside [-2^(N-1), 2^(N-1)-1]. Negate gives ~A+1, with `ovf` set only when A is 1 followed by zeros.
- R10: `ovf` is 0 whenever `fmt` is unsigned. `oor` is 0 whenever `fmt` is one of the signed encodings.
- R11: When `op` is 3, `res` is all zeros and both flags are 0, whatever the encoding.
- R12: Negative zero at the inputs (1 followed by zeros in sign-magnitude, all ones in one's complement) behaves as the value zero.
- R13: The behaviour above holds for any N of 2 or more, including widths other than 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand (A) |
| opb | input | N | Second operand (B) |
| fmt | input | 2 | Number encoding select |
| op | input | 2 | Operation select |
| res | output | N | Result in the selected encoding |
| ovf | output | 1 | Signed overflow flag |
| oor | output | 1 | Unsigned out-of-range flag |

## Verification
The bound checker enforces several rules on every evaluation. These are: flags are zero in the encodings that do not use them, the reserved code returns all zeros, sign-magnitude never outputs negative zero, mixed-sign sign-magnitude addition never overflows, two's complement negation flags only the most negative input, and unsigned addition matches a wide reference sum. Only the bench's scenarios can show that the arithmetic value is correct in each encoding. That covers the end-around carry, the choice of the larger magnitude's sign, borrow detection, and the one's complement flag case where an operand of -(2^(N-1)-1) meets negative zero. At width 4 the bench covers these exhaustively, and at width 16 it checks them on random operands.

// File: rtl/mfa_pkg.sv
package mfa_pkg;

    typedef enum logic [1:0] {
        FMT_UNS = 2'd0,
        FMT_SM  = 2'd1,
        FMT_OC  = 2'd2,
        FMT_TC  = 2'd3
    } num_fmt_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_NEG = 2'd2,
        OP_RSV = 2'd3
    } arith_op_e;

    typedef struct packed {
        logic ovf;
        logic oor;
    } arith_flags_t;

    function automatic logic fmt_is_signed(input num_fmt_e f);
        return f != FMT_UNS;
    endfunction

endpackage

// File: rtl/mfa_ripple.sv
// Plain ripple-carry adder; also exposes the carry entering the top bit.
module mfa_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout,
    output logic         c_top_in
);
    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]   = x[i] ^ y[i] ^ c[i];
        assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end

    assign cout     = c[W];
    assign c_top_in = c[W-1];
endmodule

// File: rtl/mfa_uns_path.sv
module mfa_uns_path
    import mfa_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  arith_op_e    op,
    output logic [N-1:0] res,
    output logic         oor
);
    logic [N-1:0] x_in;
    logic [N-1:0] y_in;
    logic         c0;
    logic         carry;
    logic         unused_ctop;

    // add: a+b ; sub: a+~b+1 ; negate: 0+~a+1
    always_comb begin
        x_in = a;
        y_in = b;
        c0   = 1'b0;
        case (op)
            OP_SUB: begin
                y_in = ~b;
                c0   = 1'b1;
            end
            OP_NEG: begin
                x_in = '0;
                y_in = ~a;
                c0   = 1'b1;
            end
            default: ;
        endcase
    end

    mfa_ripple #(.W(N)) u_add (
        .x(x_in), .y(y_in), .cin(c0),
        .s(res), .cout(carry), .c_top_in(unused_ctop)
    );

    // carry for add, borrow (inverted carry) for sub and negate
    assign oor = (op == OP_ADD) ? carry : ~carry;
endmodule

// File: rtl/mfa_sm_path.sv
module mfa_sm_path
    import mfa_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  arith_op_e    op,
    output logic [N-1:0] res,
    output logic         ovf
);
    localparam int M = N - 1;

    logic [M-1:0] mag_a;
    logic [M-1:0] mag_b;
    logic         sgn_a;
    logic         sgn_b;

    assign mag_a = a[M-1:0];
    assign mag_b = b[M-1:0];
    assign sgn_a = a[N-1];
    assign sgn_b = (op == OP_SUB) ? ~b[N-1] : b[N-1];

    logic [M-1:0] mag_sum;
    logic         mag_carry;
    logic         unused_c_sum;

    mfa_ripple #(.W(M)) u_sum (
        .x(mag_a), .y(mag_b), .cin(1'b0),
        .s(mag_sum), .cout(mag_carry), .c_top_in(unused_c_sum)
    );

    // magnitude compare: carry out of mag_a - mag_b means mag_a >= mag_b
    logic [M-1:0] unused_cmp_diff;
    logic         a_ge_b;
    logic         unused_c_cmp;

    mfa_ripple #(.W(M)) u_cmp (
        .x(mag_a), .y(~mag_b), .cin(1'b1),
        .s(unused_cmp_diff), .cout(a_ge_b), .c_top_in(unused_c_cmp)
    );

    logic [M-1:0] mag_big;
    logic [M-1:0] mag_small;
    logic [M-1:0] mag_diff;
    logic         unused_c_diff;
    logic         unused_ct_diff;

    assign mag_big   = a_ge_b ? mag_a : mag_b;
    assign mag_small = a_ge_b ? mag_b : mag_a;

    mfa_ripple #(.W(M)) u_diff (
        .x(mag_big), .y(~mag_small), .cin(1'b1),
        .s(mag_diff), .cout(unused_c_diff), .c_top_in(unused_ct_diff)
    );

    logic [M-1:0] mag_out;
    logic         sgn_out;

    always_comb begin
        ovf = 1'b0;
        if (op == OP_NEG) begin
            mag_out = mag_a;
            sgn_out = ~sgn_a;
        end else if (sgn_a == sgn_b) begin
            mag_out = mag_sum;
            sgn_out = sgn_a;
            ovf     = mag_carry;
        end else begin
            mag_out = mag_diff;
            sgn_out = a_ge_b ? sgn_a : sgn_b;
        end
        if (mag_out == '0) begin
            sgn_out = 1'b0;
        end
    end

    assign res = {sgn_out, mag_out};
endmodule

// File: rtl/mfa_cpl_path.sv
// Shared path for one's and two's complement.
module mfa_cpl_path
    import mfa_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  arith_op_e    op,
    input  logic         twos,
    output logic [N-1:0] res,
    output logic         ovf
);
    logic [N-1:0] x_in;
    logic [N-1:0] y_in;
    logic         c0;

    always_comb begin
        x_in = a;
        y_in = b;
        c0   = 1'b0;
        case (op)
            OP_SUB: begin
                y_in = ~b;
                c0   = twos;
            end
            OP_NEG: begin
                x_in = ~a;
                y_in = '0;
                c0   = twos;
            end
            default: ;
        endcase
    end

    logic [N-1:0] first_sum;
    logic         first_cout;
    logic         first_ctop;

    mfa_ripple #(.W(N)) u_first (
        .x(x_in), .y(y_in), .cin(c0),
        .s(first_sum), .cout(first_cout), .c_top_in(first_ctop)
    );

    // end-around pass for one's complement
    logic [N-1:0] wrap_sum;
    logic         unused_wrap_cout;
    logic         unused_wrap_ctop;

    mfa_ripple #(.W(N)) u_wrap (
        .x(first_sum), .y('0), .cin(first_cout & ~twos),
        .s(wrap_sum), .cout(unused_wrap_cout), .c_top_in(unused_wrap_ctop)
    );

    assign res = twos ? first_sum : wrap_sum;
    assign ovf = first_cout ^ first_ctop;
endmodule

// File: rtl/mfa_addsub.sv
module mfa_addsub
    import mfa_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    input  logic [1:0]   fmt,
    input  logic [1:0]   op,
    output logic [N-1:0] res,
    output logic         ovf,
    output logic         oor
);
    num_fmt_e  fmt_sel;
    arith_op_e op_sel;

    assign fmt_sel = num_fmt_e'(fmt);
    assign op_sel  = arith_op_e'(op);

    logic [N-1:0] uns_res;
    logic         uns_oor;
    logic [N-1:0] sm_res;
    logic         sm_ovf;
    logic [N-1:0] cpl_res;
    logic         cpl_ovf;

    mfa_uns_path #(.N(N)) u_uns (
        .a(opa), .b(opb), .op(op_sel), .res(uns_res), .oor(uns_oor)
    );

    mfa_sm_path #(.N(N)) u_sm (
        .a(opa), .b(opb), .op(op_sel), .res(sm_res), .ovf(sm_ovf)
    );

    mfa_cpl_path #(.N(N)) u_cpl (
        .a(opa), .b(opb), .op(op_sel), .twos(fmt_sel == FMT_TC),
        .res(cpl_res), .ovf(cpl_ovf)
    );

    arith_flags_t flg;

    always_comb begin
        res = '0;
        flg = '0;
        if (op_sel != OP_RSV) begin
            case (fmt_sel)
                FMT_UNS: begin
                    res     = uns_res;
                    flg.oor = uns_oor;
                end
                FMT_SM: begin
                    res     = sm_res;
                    flg.ovf = sm_ovf;
                end
                default: begin
                    res     = cpl_res;
                    flg.ovf = cpl_ovf;
                end
            endcase
        end
        if (!fmt_is_signed(fmt_sel)) begin
            flg.ovf = 1'b0;
        end
    end

    assign ovf = flg.ovf;
    assign oor = flg.oor;
endmodule

// File: rtl/mfa_addsub_chk.sv
module mfa_addsub_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] opa,
    input logic [N-1:0] opb,
    input logic [1:0]   fmt,
    input logic [1:0]   op,
    input logic [N-1:0] res,
    input logic         ovf,
    input logic         oor
);
    localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

    logic [N:0] wide_sum;
    assign wide_sum = {1'b0, opa} + {1'b0, opb};

    always_comb begin
        p_no_overflow_r10: assert (!(fmt == 2'd0 && ovf))
            else $error("ovf set in unsigned encoding");
        p_no_range_r10: assert (!(fmt != 2'd0 && oor))
            else $error("oor set in a signed encoding");
        p_reserved_zero_r11: assert (!(op == 2'd3) || (res == '0 && !ovf && !oor))
            else $error("reserved op gave nonzero output");
        p_sm_no_negzero_r6: assert (!(fmt == 2'd1 && op != 2'd3) || res != MOST_NEG)
            else $error("sign-magnitude negative zero produced");
        p_sm_mixed_no_ovf_r5: assert (!(fmt == 2'd1 && op == 2'd0 && opa[N-1] != opb[N-1]) || !ovf)
            else $error("mixed-sign sign-magnitude add overflowed");
        p_tc_neg_ovf_r9: assert (!(fmt == 2'd3 && op == 2'd2) || (ovf == (opa == MOST_NEG)))
            else $error("two's complement negate flag wrong");
        p_uns_add_r2: assert (!(fmt == 2'd0 && op == 2'd0) || ({oor, res} == wide_sum))
            else $error("unsigned add mismatch");
    end
endmodule

bind mfa_addsub mfa_addsub_chk #(.N(N)) u_chk (
    .opa(opa), .opb(opb), .fmt(fmt), .op(op), .res(res), .ovf(ovf), .oor(oor)
);

// File: tb/sim_mfa_addsub.sv
`timescale 1ns/1ps
module sim_mfa_addsub;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    logic [3:0]  a4 = '0;
    logic [3:0]  b4 = '0;
    logic [15:0] a16 = '0;
    logic [15:0] b16 = '0;
    logic [1:0]  fmt = '0;
    logic [1:0]  op  = '0;
    logic [3:0]  res4;
    logic [15:0] res16;
    logic        ovf4, oor4, ovf16, oor16;

    mfa_addsub #(.N(4)) u0 (
        .opa(a4), .opb(b4), .fmt(fmt), .op(op), .res(res4), .ovf(ovf4), .oor(oor4)
    );

    mfa_addsub #(.N(16)) u1 (
        .opa(a16), .opb(b16), .fmt(fmt), .op(op), .res(res16), .ovf(ovf16), .oor(oor16)
    );

    // Directed vectors: {req, fmt, op, a, b, res, ovf, oor}
    localparam int NVEC = 20;
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd1,  2'd3, 2'd0, 4'b0011, 4'b1101, 4'b0000, 1'b0, 1'b0},
        {4'd6,  2'd1, 2'd2, 4'b0011, 4'b0000, 4'b1011, 1'b0, 1'b0},
        {4'd8,  2'd2, 2'd2, 4'b0011, 4'b0000, 4'b1100, 1'b0, 1'b0},
        {4'd9,  2'd3, 2'd2, 4'b0011, 4'b0000, 4'b1101, 1'b0, 1'b0},
        {4'd9,  2'd3, 2'd2, 4'b1000, 4'b0000, 4'b1000, 1'b1, 1'b0},
        {4'd4,  2'd1, 2'd0, 4'b0111, 4'b0001, 4'b0000, 1'b1, 1'b0},
        {4'd5,  2'd1, 2'd0, 4'b0011, 4'b1011, 4'b0000, 1'b0, 1'b0},
        {4'd5,  2'd1, 2'd0, 4'b0010, 4'b1101, 4'b1011, 1'b0, 1'b0},
        {4'd2,  2'd0, 2'd0, 4'b1111, 4'b0001, 4'b0000, 1'b0, 1'b1},
        {4'd3,  2'd0, 2'd1, 4'b0000, 4'b0001, 4'b1111, 1'b0, 1'b1},
        {4'd7,  2'd2, 2'd0, 4'b0011, 4'b1100, 4'b1111, 1'b0, 1'b0},
        {4'd8,  2'd2, 2'd0, 4'b1000, 4'b1111, 4'b1000, 1'b1, 1'b0},
        {4'd12, 2'd2, 2'd0, 4'b1111, 4'b0011, 4'b0011, 1'b0, 1'b0},
        {4'd12, 2'd1, 2'd0, 4'b1000, 4'b0011, 4'b0011, 1'b0, 1'b0},
        {4'd10, 2'd0, 2'd0, 4'b0111, 4'b0001, 4'b1000, 1'b0, 1'b0},
        {4'd10, 2'd3, 2'd0, 4'b1111, 4'b0001, 4'b0000, 1'b0, 1'b0},
        {4'd11, 2'd3, 2'd3, 4'b0111, 4'b0111, 4'b0000, 1'b0, 1'b0},
        {4'd6,  2'd1, 2'd1, 4'b1011, 4'b1011, 4'b0000, 1'b0, 1'b0},
        {4'd7,  2'd2, 2'd1, 4'b0101, 4'b0011, 4'b0010, 1'b0, 1'b0},
        {4'd3,  2'd0, 2'd2, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}
    };

    function automatic string req_tag(input int f, input int o, input longint a,
                                      input longint b, input int w);
        bit sa, sb;
        if (o == 3) return "R11";
        case (f)
            0: return (o == 0) ? "R2" : "R3";
            1: begin
                if (o == 2) return "R6";
                sa = a[w-1];
                sb = (o == 1) ? ~b[w-1] : b[w-1];
                return (sa == sb) ? "R4" : "R5";
            end
            2: return (o == 2) ? "R8" : "R7";
            default: return "R9";
        endcase
    endfunction

    function automatic longint oc_val(input longint x, input int w);
        longint mask = (longint'(1) << w) - 1;
        if (x[w-1]) return -((~x) & mask);
        return x;
    endfunction

    function automatic longint tc_val(input longint x, input int w);
        longint half = longint'(1) << (w - 1);
        if (x[w-1]) return x - (half << 1);
        return x;
    endfunction

    // mode: 0 exact result, 1 either zero encoding, 2 result not checked
    function automatic void model(input int w, input int f, input int o,
                                  input longint a, input longint b,
                                  output longint er, output bit eov, output bit eoor,
                                  output int mode);
        longint mask = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        longint mmask = half - 1;
        longint v, bb, raw, ma, mb, mag;
        bit sa, sb, sg;
        er = 0; eov = 0; eoor = 0; mode = 0;
        if (o == 3) return;
        case (f)
            0: begin
                if (o == 0) begin
                    er = (a + b) & mask; eoor = (a + b) > mask;
                end else if (o == 1) begin
                    er = (a - b) & mask; eoor = a < b;
                end else begin
                    er = (-a) & mask; eoor = a != 0;
                end
            end
            1: begin
                ma = a & mmask; mb = b & mmask;
                sa = a[w-1];
                sb = (o == 1) ? ~b[w-1] : b[w-1];
                if (o == 2) begin
                    mag = ma; sg = ~sa;
                end else if (sa == sb) begin
                    mag = ma + mb; eov = mag > mmask; mag = mag & mmask; sg = sa;
                end else if (ma >= mb) begin
                    mag = ma - mb; sg = sa;
                end else begin
                    mag = mb - ma; sg = sb;
                end
                if (mag == 0) sg = 0;
                er = (longint'(sg) << (w - 1)) | mag;
            end
            2: begin
                if (o == 2) begin
                    er = (~a) & mask;
                end else begin
                    bb = (o == 1) ? ((~b) & mask) : b;
                    raw = (a + bb) & mask;
                    sa = a[w-1]; sb = bb[w-1];
                    eov = (sa == sb) && (raw[w-1] != sa);
                    v = oc_val(a, w) + oc_val(bb, w);
                    if (eov) mode = 2;
                    else if (v == 0) mode = 1;
                    else er = (v < 0) ? ((~(-v)) & mask) : v;
                end
            end
            default: begin
                if (o == 2) v = -tc_val(a, w);
                else if (o == 1) v = tc_val(a, w) - tc_val(b, w);
                else v = tc_val(a, w) + tc_val(b, w);
                er = v & mask;
                eov = (v > half - 1) || (v < -half);
            end
        endcase
    endfunction

    task automatic drive(input int f, input int o, input longint a, input longint b);
        @(posedge clk);
        fmt <= 2'(f);
        op  <= 2'(o);
        a4  <= a[3:0];
        b4  <= b[3:0];
        a16 <= a[15:0];
        b16 <= b[15:0];
        @(negedge clk);
    endtask

    task automatic check(input string req, input int w, input longint ar, input bit aov,
                         input bit aoor, input longint er, input bit eov, input bit eoor,
                         input int mode);
        longint mask = (longint'(1) << w) - 1;
        bit ok;
        ok = (aov == eov) && (aoor == eoor);
        if (mode == 0) ok = ok && (ar == er);
        if (mode == 1) ok = ok && (ar == 0 || ar == mask);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s w=%0d fmt=%0d op=%0d: got res=%h ovf=%0b oor=%0b, expected res=%h ovf=%0b oor=%0b",
                     req, w, fmt, op, ar, aov, aoor, er, eov, eoor);
        end
    endtask

    task automatic run_model(input int w, input int f, input int o, input longint a,
                             input longint b, input string extra);
        longint er;
        bit eov, eoor;
        int mode;
        model(w, f, o, a, b, er, eov, eoor, mode);
        drive(f, o, a, b);
        if (w == 4)
            check({req_tag(f, o, a, b, w), extra}, w, longint'(res4), ovf4, oor4, er, eov, eoor, mode);
        else
            check({req_tag(f, o, a, b, w), extra}, w, longint'(res16), ovf16, oor16, er, eov, eoor, mode);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // directed vectors (R1 encodings, R10 flag isolation, R12 negative zero)
        for (int i = 0; i < NVEC; i++) begin
            logic [21:0] v;
            v = VEC[i];
            drive(int'(v[17:16]), int'(v[15:14]), longint'(v[13:10]), longint'(v[9:6]));
            check($sformatf("R%0d table#%0d", v[21:18], i), 4, longint'(res4), ovf4, oor4,
                  longint'(v[5:2]), v[1], v[0], 0);
        end

        // exhaustive at width 4: every encoding, operation and operand pair
        for (int f = 0; f < 4; f++) begin
            for (int o = 0; o < 4; o++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        run_model(4, f, o, longint'(a), longint'(b), "");
                    end
                end
            end
        end

        // random at width 16 (R13)
        for (int k = 0; k < 3000; k++) begin
            int f, o;
            longint a, b;
            f = int'($urandom_range(0, 3));
            o = int'($urandom_range(0, 3));
            a = longint'($urandom_range(0, 65535));
            b = longint'($urandom_range(0, 65535));
            if (k < 8) begin
                a = (k[0]) ? 64'h8000 : 64'hFFFF;
                b = (k[1]) ? 64'h7FFF : 64'h0000;
            end
            run_model(16, f, o, a, b, " R13");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule